// File: doc/BRIEF.md
# Dataflow Issue-Cycle Calculator

This block is a performance model that sits beside an instruction stream that has already been renamed. It receives one instruction per cycle. Each instruction has a physical destination tag, two optional physical source tags and a unit class. For each instruction the block works out the cycle in which that instruction would execute on a chosen machine model, and it reports that cycle one clock later. When an end-of-program marker arrives, the block gives the instruction count and the total cycle count of the program. The testbench, or any other consumer, divides the two counts to obtain the parallelism figure.

The model starts as the ideal machine. That machine is bounded only by true read-after-write dependencies: it has no cap on instructions per cycle, and branches cost nothing. Three optional limits can be added on top of it:
- an issue-width cap;
- per-class unit limits, for an ALU class and a multiplier class;
- an in-order rule.

With these limits the block shows how far a concrete machine falls short of the ideal. A ready-cycle table keyed by physical tag records when each result becomes available. Occupancy counters cover a bounded window of cycles and record how busy each cycle already is.

Top module: `df_issue_calc`

## Requirements
- R1: An instruction's earliest cycle is one more than the largest ready cycle among its sources whose use flag is set. A source whose use flag is clear is ignored. A tag that no instruction has written since `start` has ready cycle 0, so an instruction without producers lands in cycle 1.
- R2: When a limit input is 0, that limit is off. With all limits 0 and in-order off, any number of instructions share one cycle. Only true dependencies delay an instruction.
- R3: With `cfg_issue_width` = W > 0, no cycle holds more than W instructions. An instruction whose earliest cycle is full takes the first later cycle that has room.
- R4: `in_cls` 0 is the ALU class and 1 is the multiplier class. With `cfg_alu_lim` or `cfg_mul_lim` = L > 0, no cycle holds more than L instructions of that class. An instruction that would exceed the limit moves to a later cycle.
- R5: With `cfg_inorder` = 1, an instruction never lands in an earlier cycle than the previous placed instruction of the same program.
- R6: One clock after an instruction is accepted (`in_valid` high and `start` low), `res_valid` is high for one cycle and `res_cycle` holds the assigned cycle.
- R7: One clock after `prog_end` is accepted, `done` is high for exactly one cycle. In that cycle `instr_count` is the number of instructions accepted since `start`, and `cycle_count` is the largest cycle assigned to any of them.
- R8: If no cycle from the earliest cycle up to DEPTH (32) has room, then:
  - `res_cycle` reports 0;
  - `overflow` sets and stays set until `start`;
  - the instruction is still counted;
  - neither its destination's ready cycle nor any occupancy is updated.
- R9: A `start` pulse clears the ready table, the occupancy counters, both counts, `overflow` and the in-order history. It takes priority over an instruction or marker in the same cycle; that instruction or marker is dropped.
- R10: After reset, `res_valid`, `done` and `overflow` are low, and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears all per-program state |
| cfg_inorder | input | 1 | In-order placement rule enable |
| cfg_issue_width | input | 8 | Instructions per cycle cap, 0 = no cap |
| cfg_alu_lim | input | 8 | ALU-class units per cycle, 0 = no limit |
| cfg_mul_lim | input | 8 | Multiplier-class units per cycle, 0 = no limit |
| in_valid | input | 1 | Instruction present |
| in_dst | input | 6 | Physical destination tag |
| in_src_a | input | 6 | First physical source tag |
| in_use_a | input | 1 | First source is read |
| in_src_b | input | 6 | Second physical source tag |
| in_use_b | input | 1 | Second source is read |
| in_cls | input | 1 | Unit class: 0 ALU, 1 multiplier |
| prog_end | input | 1 | End-of-program marker |
| res_valid | output | 1 | Per-instruction result strobe |
| res_cycle | output | 6 | Assigned cycle, 0 on overflow |
| overflow | output | 1 | Sticky window-overflow flag |
| done | output | 1 | Program totals valid (one cycle) |
| instr_count | output | 16 | Instructions accepted since start |
| cycle_count | output | 6 | Largest assigned cycle |

## Verification
Results follow their stimulus by one clock:
- `res_valid` and `res_cycle` come one clock after an accepted instruction;
- `done` and the two counts come one clock after an accepted `prog_end`;
- the effect of `start` shows one clock after the pulse.

The bench drives every input on a falling edge. It reads the outputs at the next falling edge, which is half a period after the single rising edge that registers them. `done` is checked again one cycle later to confirm that it is a pulse. State that is not visible at the ports is checked through later results. For example, the ready cycle of a destination that overflowed is observed through the cycle given to the next instruction that reads that tag.

// File: rtl/df_issue_pkg.sv
package df_issue_pkg;

  typedef enum logic {
    UNIT_ALU = 1'b0,
    UNIT_MUL = 1'b1
  } unit_cls_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // earliest cycle: one past the latest used producer, optionally no earlier
  // than the previous placement when the in-order rule is on
  function automatic int unsigned earliest_cycle(input int unsigned rdy_a,
                                                 input int unsigned rdy_b,
                                                 input logic use_a,
                                                 input logic use_b,
                                                 input logic inorder,
                                                 input int unsigned prev);
    int unsigned dep;
    dep = umax(use_a ? rdy_a : 0, use_b ? rdy_b : 0) + 1;
    return inorder ? umax(dep, prev) : dep;
  endfunction

  // a zero limit means unlimited
  function automatic logic has_room(input int unsigned used, input int unsigned lim);
    return (lim == 0) || (used < lim);
  endfunction

endpackage

// File: rtl/df_ready_table.sv
module df_ready_table #(
  parameter int NTAG = 64,
  parameter int CW   = 6,
  localparam int TW  = $clog2(NTAG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW-1:0] rd_a_tag,
  input  logic [TW-1:0] rd_b_tag,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_tag,
  input  logic [CW-1:0] wr_cyc,
  output logic [CW-1:0] rd_a_cyc,
  output logic [CW-1:0] rd_b_cyc
);

  logic [CW-1:0] rdy_q [NTAG];

  for (genvar g = 0; g < NTAG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rdy_q[g] <= '0;
      else if (clr)                            rdy_q[g] <= '0;
      else if (wr_en && (wr_tag == TW'(g)))    rdy_q[g] <= wr_cyc;
    end
  end

  assign rd_a_cyc = rdy_q[rd_a_tag];
  assign rd_b_cyc = rdy_q[rd_b_tag];

endmodule

// File: rtl/df_slot_finder.sv
module df_slot_finder
  import df_issue_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6,
  parameter int OCW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [CW-1:0]  earliest,
  input  unit_cls_e      cls,
  input  logic [OCW-1:0] lim_width,
  input  logic [OCW-1:0] lim_alu,
  input  logic [OCW-1:0] lim_mul,
  input  logic           commit,
  output logic           found,
  output logic [CW-1:0]  slot
);

  logic [OCW-1:0] occ_tot [DEPTH];
  logic [OCW-1:0] occ_alu [DEPTH];
  logic [OCW-1:0] occ_mul [DEPTH];
  logic [DEPTH-1:0] fit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cycle
    logic cls_ok;
    logic take;
    assign cls_ok = (cls == UNIT_MUL) ? has_room(32'(occ_mul[g]), 32'(lim_mul))
                                      : has_room(32'(occ_alu[g]), 32'(lim_alu));
    assign fit[g] = (CW'(g + 1) >= earliest) && cls_ok &&
                    has_room(32'(occ_tot[g]), 32'(lim_width));
    assign take = commit && found && (slot == CW'(g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_tot[g] <= '0;
        occ_alu[g] <= '0;
        occ_mul[g] <= '0;
      end else if (clr) begin
        occ_tot[g] <= '0;
        occ_alu[g] <= '0;
        occ_mul[g] <= '0;
      end else if (take) begin
        if (occ_tot[g] != '1) occ_tot[g] <= occ_tot[g] + 1'b1;
        if (cls == UNIT_MUL) begin
          if (occ_mul[g] != '1) occ_mul[g] <= occ_mul[g] + 1'b1;
        end else begin
          if (occ_alu[g] != '1) occ_alu[g] <= occ_alu[g] + 1'b1;
        end
      end
    end
  end

  // lowest fitting cycle wins
  always_comb begin
    found = 1'b0;
    slot  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (fit[i]) begin
        found = 1'b1;
        slot  = CW'(i + 1);
      end
    end
  end

endmodule

// File: rtl/df_issue_calc.sv
module df_issue_calc
  import df_issue_pkg::*;
#(
  parameter int NTAG  = 64,
  parameter int DEPTH = 32,
  parameter int OCW   = 8,
  parameter int ICW   = 16,
  localparam int TW   = $clog2(NTAG),
  localparam int CW   = $clog2(DEPTH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           cfg_inorder,
  input  logic [OCW-1:0] cfg_issue_width,
  input  logic [OCW-1:0] cfg_alu_lim,
  input  logic [OCW-1:0] cfg_mul_lim,
  input  logic           in_valid,
  input  logic [TW-1:0]  in_dst,
  input  logic [TW-1:0]  in_src_a,
  input  logic           in_use_a,
  input  logic [TW-1:0]  in_src_b,
  input  logic           in_use_b,
  input  logic           in_cls,
  input  logic           prog_end,
  output logic           res_valid,
  output logic [CW-1:0]  res_cycle,
  output logic           overflow,
  output logic           done,
  output logic [ICW-1:0] instr_count,
  output logic [CW-1:0]  cycle_count
);

  // named internal events
  logic ev_accept, ev_end, ev_place, ev_miss;

  logic [CW-1:0] rdy_a, rdy_b, earliest, slot, last_q;
  logic          found;

  logic           res_valid_q, ovf_q, done_q;
  logic [CW-1:0]  res_cycle_q, ccnt_q;
  logic [ICW-1:0] icnt_q;

  assign ev_accept = in_valid && !start;
  assign ev_end    = prog_end && !start;
  assign ev_place  = ev_accept && found;
  assign ev_miss   = ev_accept && !found;

  df_ready_table #(.NTAG(NTAG), .CW(CW)) u_ready (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .rd_a_tag (in_src_a),
    .rd_b_tag (in_src_b),
    .wr_en    (ev_place),
    .wr_tag   (in_dst),
    .wr_cyc   (slot),
    .rd_a_cyc (rdy_a),
    .rd_b_cyc (rdy_b)
  );

  assign earliest = CW'(earliest_cycle(32'(rdy_a), 32'(rdy_b), in_use_a, in_use_b,
                                       cfg_inorder, 32'(last_q)));

  df_slot_finder #(.DEPTH(DEPTH), .CW(CW), .OCW(OCW)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .earliest  (earliest),
    .cls       (unit_cls_e'(in_cls)),
    .lim_width (cfg_issue_width),
    .lim_alu   (cfg_alu_lim),
    .lim_mul   (cfg_mul_lim),
    .commit    (ev_accept),
    .found     (found),
    .slot      (slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_cycle_q <= '0;
      ovf_q       <= 1'b0;
      done_q      <= 1'b0;
      icnt_q      <= '0;
      ccnt_q      <= '0;
      last_q      <= '0;
    end else begin
      res_valid_q <= ev_accept;
      done_q      <= ev_end;
      if (start) begin
        res_cycle_q <= '0;
        ovf_q       <= 1'b0;
        icnt_q      <= '0;
        ccnt_q      <= '0;
        last_q      <= '0;
      end else if (ev_accept) begin
        icnt_q <= icnt_q + 1'b1;
        if (found) begin
          res_cycle_q <= slot;
          last_q      <= slot;
          if (slot > ccnt_q) ccnt_q <= slot;
        end else begin
          res_cycle_q <= '0;
          ovf_q       <= 1'b1;
        end
      end
    end
  end

  assign res_valid   = res_valid_q;
  assign res_cycle   = res_cycle_q;
  assign overflow    = ovf_q;
  assign done        = done_q;
  assign instr_count = icnt_q;
  assign cycle_count = ccnt_q;

endmodule

// File: rtl/df_issue_calc_chk.sv
module df_issue_calc_chk #(
  parameter int CW  = 6,
  parameter int ICW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           cfg_inorder,
  input logic           prog_end,
  input logic           ev_accept,
  input logic           ev_miss,
  input logic           res_valid,
  input logic [CW-1:0]  res_cycle,
  input logic           overflow,
  input logic           done,
  input logic [ICW-1:0] instr_count,
  input logic [CW-1:0]  cycle_count
);

  logic [CW-1:0] prev_rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          prev_rc <= '0;
    else if (start)                      prev_rc <= '0;
    else if (res_valid && res_cycle != 0) prev_rc <= res_cycle;
  end

  assert_result_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> res_valid);

  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_end && !start) |=> done);

  assert_total_covers_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_cycle != 0) |-> (cycle_count >= res_cycle));

  assert_no_overflow_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow);

  assert_miss_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (overflow && res_cycle == 0));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (instr_count == 0 && cycle_count == 0 && !overflow && !res_valid && !done));

  assert_inorder_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cfg_inorder && res_cycle != 0) |-> (res_cycle >= prev_rc));

endmodule

bind df_issue_calc df_issue_calc_chk #(.CW(CW), .ICW(ICW)) u_df_issue_calc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .cfg_inorder (cfg_inorder),
  .prog_end    (prog_end),
  .ev_accept   (ev_accept),
  .ev_miss     (ev_miss),
  .res_valid   (res_valid),
  .res_cycle   (res_cycle),
  .overflow    (overflow),
  .done        (done),
  .instr_count (instr_count),
  .cycle_count (cycle_count)
);

// File: tb/test_df_issue_calc.sv
`timescale 1ns/1ps
module test_df_issue_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_inorder = 1'b0;
  logic [7:0]  cfg_issue_width = '0, cfg_alu_lim = '0, cfg_mul_lim = '0;
  logic        in_valid = 1'b0;
  logic [5:0]  in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic        in_use_a = 1'b0, in_use_b = 1'b0, in_cls = 1'b0;
  logic        prog_end = 1'b0;
  logic        res_valid, overflow, done;
  logic [5:0]  res_cycle, cycle_count;
  logic [15:0] instr_count;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  df_issue_calc i_df_issue_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_inorder(cfg_inorder),
    .cfg_issue_width(cfg_issue_width), .cfg_alu_lim(cfg_alu_lim), .cfg_mul_lim(cfg_mul_lim),
    .in_valid(in_valid), .in_dst(in_dst), .in_src_a(in_src_a), .in_use_a(in_use_a),
    .in_src_b(in_src_b), .in_use_b(in_use_b), .in_cls(in_cls), .prog_end(prog_end),
    .res_valid(res_valid), .res_cycle(res_cycle), .overflow(overflow), .done(done),
    .instr_count(instr_count), .cycle_count(cycle_count)
  );

  // {first, mode, dst, src_a, use_a, src_b, use_b, cls, expected cycle}
  localparam int NV = 26;
  localparam logic [29:0] VEC [NV] = '{
    // mode 0 ideal: five instructions, one true dependency
    {1'b1,2'd0,6'd10,6'd2,1'b1,6'd3,1'b1,1'b0,6'd1},
    {1'b0,2'd0,6'd6,6'd7,1'b1,6'd8,1'b1,1'b0,6'd1},
    {1'b0,2'd0,6'd5,6'd8,1'b1,6'd9,1'b1,1'b1,6'd1},
    {1'b0,2'd0,6'd4,6'd8,1'b1,6'd9,1'b1,1'b0,6'd1},
    {1'b0,2'd0,6'd11,6'd10,1'b1,6'd5,1'b1,1'b0,6'd2},
    // mode 0 ideal: seven instructions, four-deep chain
    {1'b1,2'd0,6'd20,6'd1,1'b1,6'd1,1'b1,1'b0,6'd1},
    {1'b0,2'd0,6'd21,6'd2,1'b1,6'd20,1'b1,1'b0,6'd2},
    {1'b0,2'd0,6'd22,6'd21,1'b1,6'd20,1'b1,1'b0,6'd3},
    {1'b0,2'd0,6'd23,6'd7,1'b1,6'd8,1'b1,1'b0,6'd1},
    {1'b0,2'd0,6'd24,6'd22,1'b1,6'd7,1'b1,1'b0,6'd4},
    {1'b0,2'd0,6'd25,6'd20,1'b1,6'd20,1'b1,1'b0,6'd2},
    {1'b0,2'd0,6'd26,6'd7,1'b1,6'd7,1'b1,1'b0,6'd1},
    // mode 1: width 2, two ALUs, one multiplier
    {1'b1,2'd1,6'd10,6'd2,1'b1,6'd3,1'b1,1'b0,6'd1},
    {1'b0,2'd1,6'd11,6'd10,1'b1,6'd5,1'b1,1'b0,6'd2},
    {1'b0,2'd1,6'd12,6'd7,1'b1,6'd8,1'b1,1'b0,6'd1},
    {1'b0,2'd1,6'd13,6'd8,1'b1,6'd9,1'b1,1'b1,6'd2},
    {1'b0,2'd1,6'd14,6'd8,1'b1,6'd9,1'b1,1'b0,6'd3},
    // mode 2: in-order, unlimited; third entry has an unused source
    {1'b1,2'd2,6'd10,6'd0,1'b0,6'd0,1'b0,1'b0,6'd1},
    {1'b0,2'd2,6'd11,6'd10,1'b1,6'd0,1'b0,1'b0,6'd2},
    {1'b0,2'd2,6'd12,6'd11,1'b0,6'd0,1'b0,1'b0,6'd2},
    {1'b0,2'd2,6'd13,6'd0,1'b0,6'd0,1'b0,1'b1,6'd2},
    // mode 3: two ALUs, one multiplier, no width cap
    {1'b1,2'd3,6'd30,6'd1,1'b1,6'd2,1'b1,1'b1,6'd1},
    {1'b0,2'd3,6'd31,6'd1,1'b1,6'd2,1'b1,1'b1,6'd2},
    {1'b0,2'd3,6'd32,6'd3,1'b1,6'd4,1'b1,1'b0,6'd1},
    {1'b0,2'd3,6'd33,6'd3,1'b1,6'd4,1'b1,1'b0,6'd1},
    {1'b0,2'd3,6'd34,6'd3,1'b1,6'd4,1'b1,1'b0,6'd2}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // all tasks are entered just after a falling edge
  task automatic begin_prog(input int mode);
    cfg_inorder     = (mode == 2);
    cfg_issue_width = (mode == 1) ? 8'd2 : 8'd0;
    cfg_alu_lim     = (mode == 1 || mode == 3) ? 8'd2 : 8'd0;
    cfg_mul_lim     = (mode == 1 || mode == 3) ? 8'd1 : 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [5:0] d, input logic [5:0] a, input logic ua,
                      input logic [5:0] b, input logic ub, input logic c,
                      input int exp, input string req);
    in_valid = 1'b1; in_dst = d; in_src_a = a; in_use_a = ua;
    in_src_b = b; in_use_b = ub; in_cls = c;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", "res_valid", int'(res_valid), 1);
    check(req, "res_cycle", int'(res_cycle), exp);
  endtask

  task automatic end_prog(input int exp_n, input int exp_c, input int exp_ovf);
    prog_end = 1'b1;
    @(negedge clk);
    prog_end = 1'b0;
    check("R7", "done", int'(done), 1);
    check("R7", "instr_count", int'(instr_count), exp_n);
    check("R7", "cycle_count", int'(cycle_count), exp_c);
    check("R8", "overflow", int'(overflow), exp_ovf);
    @(negedge clk);
    check("R7", "done pulse", int'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int pn, pc;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "res_valid", int'(res_valid), 0);
    check("R10", "done", int'(done), 0);
    check("R10", "overflow", int'(overflow), 0);
    check("R10", "instr_count", int'(instr_count), 0);
    check("R10", "cycle_count", int'(cycle_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    pn = 0; pc = 0;
    for (int i = 0; i < NV; i++) begin
      logic [29:0] e;
      string req;
      e = VEC[i];
      if (e[29]) begin
        if (i > 0) end_prog(pn, pc, 0);
        begin_prog(int'(e[28:27]));
        pn = 0; pc = 0;
      end
      case (e[28:27])
        2'd0:    req = "R1 R2";
        2'd1:    req = "R3 R4";
        2'd2:    req = "R5";
        default: req = "R4";
      endcase
      send(e[26:21], e[20:15], e[14], e[13:8], e[7], e[6], int'(e[5:0]), req);
      pn++;
      if (int'(e[5:0]) > pc) pc = int'(e[5:0]);
    end
    end_prog(pn, pc, 0);

    // R8 window overflow: a 33-deep chain in ideal mode
    begin_prog(0);
    for (int k = 0; k < 33; k++)
      send(6'(k + 1), 6'(k), (k > 0), 6'd0, 1'b0, 1'b0, (k < 32) ? k + 1 : 0, "R8");
    check("R8", "overflow set", int'(overflow), 1);
    // tag 33 was never written, so a reader of it lands in cycle 1
    send(6'd40, 6'd33, 1'b1, 6'd0, 1'b0, 1'b0, 1, "R8");
    check("R8", "overflow sticky", int'(overflow), 1);
    end_prog(34, 32, 1);

    // R9 start clears state and wins over a same-cycle instruction and marker
    start = 1'b1; in_valid = 1'b1; prog_end = 1'b1;
    in_dst = 6'd50; in_use_a = 1'b0; in_use_b = 1'b0; in_cls = 1'b0;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; prog_end = 1'b0;
    check("R9", "res_valid dropped", int'(res_valid), 0);
    check("R9", "done dropped", int'(done), 0);
    check("R9", "overflow cleared", int'(overflow), 0);
    check("R9", "instr_count cleared", int'(instr_count), 0);
    check("R9", "cycle_count cleared", int'(cycle_count), 0);
    // ready table cleared: tag 31 held cycle 31 before start
    send(6'd51, 6'd31, 1'b1, 6'd0, 1'b0, 1'b0, 1, "R9");
    end_prog(1, 1, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule